// File: doc/BRIEF.md
# SCSI DMA Channel Control Register Bank

This block is the software-visible control front of a bus-master DMA channel that sits beside a SCSI protocol core. It has eight word-wide registers. Software loads the starting transfer count, the starting memory address and the starting descriptor-list address. A write to the command register then starts, idles or aborts the channel. The block drives a DMA-enable level and a one-cycle cancel strobe toward the SCSI core, and it keeps a small sticky status word.

Status has two clearing policies, selected by an input that mirrors one bit of a separate bus-control register. In the write-to-clear policy, software writes ones to the bits it wants to drop. In the read-to-clear policy, status writes are ignored, and reading status returns the current value and then drops the error, abort and done flags. A live interrupt level from the SCSI core is merged into every status read.

Register reads are combinational from the addressed word. Writes and read side effects take effect at the clock edge that samples the strobe.

Top module: `scsi_dma_ctrl`

## Requirements
- R1: After reset the registers read as follows:
  - command, start count, start address, start descriptor address, working count and status read 0;
  - working address reads 0xFFFFFFFF and working descriptor address reads 0xFFFFFFFD;
  - dma_en and xfer_cancel are 0.
- R2: The word offsets are 0 command, 1 start count, 2 start address, 3 working count, 4 working address, 5 status, 6 start descriptor address and 7 working descriptor address. A write to offset 0 stores write-data bits [7:0] as the command. Bits [31:8] of the command read as 0.
- R3: A command write with bits [1:0] = 3 (START) has these effects, all visible from the next cycle:
  - the working count, working address and working descriptor address take the start count, start address and start descriptor address;
  - status bits [5:0] clear;
  - dma_en goes to 1.
- R4: A command write with bits [1:0] = 0 (IDLE) drives dma_en to 0 from the next cycle. A command write with bits [1:0] = 1 (BLAST) only stores the command and leaves dma_en unchanged.
- R5: A command write with bits [1:0] = 2 (ABORT) raises xfer_cancel for exactly one cycle, in the cycle after the write. It leaves dma_en unchanged.
- R6: With clr_on_read = 0, a status write clears each of the flags error (bit 1), abort (bit 2) and done (bit 3) whose bit is 1 in the write data. Other status bits are unaffected.
- R7: With clr_on_read = 1, status writes have no effect. A status read returns the current flags, and error, abort and done read as 0 from the next cycle.
- R8: Status bit 4 reads as 1 whenever scsi_irq is 1, independent of the stored status.
- R9: Writes to offsets 3, 4 and 7 are dropped.
- R10: stat_set bits 0, 1 and 2 set error, abort and done. A set takes priority over a clear in the same cycle, whether the clear comes from a write, a read or START.
- R11: Offsets 1, 2 and 6 store the full 32-bit write data and read it back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (drives the read-to-clear side effect) |
| reg_addr | input | 3 | Word offset |
| reg_wdata | input | 32 | Write data |
| clr_on_read | input | 1 | Status policy: 0 write-to-clear, 1 read-to-clear |
| scsi_irq | input | 1 | Interrupt level from the SCSI core |
| stat_set | input | 3 | Set pulses for error, abort and done |
| reg_rdata | output | 32 | Read data for reg_addr |
| dma_en | output | 1 | DMA enable toward the SCSI core |
| xfer_cancel | output | 1 | One-cycle cancel strobe toward the SCSI core |

## Verification
The bench drives each status clearing policy against a flag set that arrives in the same cycle as the clear. A design that gave the clear priority would lose a done or error event.

It checks that START copies the starting values before any later write can change them. It also checks that the working registers keep their values when written. A design that decoded offsets 3, 4 or 7 as writable would corrupt transfer progress.

Under the read-to-clear policy, the bench checks that the first status read still returns the flags. It also checks that a status write changes nothing. A design that cleared before returning the value would hide completions, and one that honoured the write would clear flags silently.

It checks that the interrupt level appears in bit 4 without being stored, and that the cancel strobe lasts only one cycle.

// File: rtl/scsi_dma_pkg.sv
package scsi_dma_pkg;
    localparam int DATA_W   = 32;
    localparam int NUM_REGS = 8;
    localparam int ADDR_W   = $clog2(NUM_REGS);
    localparam int STAT_W   = 6;
    localparam int CMD_W    = 8;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_BLAST = 2'd1,
        OP_ABORT = 2'd2,
        OP_START = 2'd3
    } dma_op_e;

    localparam logic [ADDR_W-1:0] OFS_CMD  = 3'd0;
    localparam logic [ADDR_W-1:0] OFS_SCNT = 3'd1;
    localparam logic [ADDR_W-1:0] OFS_SADR = 3'd2;
    localparam logic [ADDR_W-1:0] OFS_WCNT = 3'd3;
    localparam logic [ADDR_W-1:0] OFS_WADR = 3'd4;
    localparam logic [ADDR_W-1:0] OFS_STAT = 3'd5;
    localparam logic [ADDR_W-1:0] OFS_SDSC = 3'd6;
    localparam logic [ADDR_W-1:0] OFS_WDSC = 3'd7;
endpackage

// File: rtl/scsi_dma_cmd_dec.sv
module scsi_dma_cmd_dec
    import scsi_dma_pkg::*;
(
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        op_bits,
    output logic              cmd_wr,
    output logic              op_start,
    output logic              op_idle,
    output logic              op_abort
);
    dma_op_e op;

    always_comb begin
        op       = dma_op_e'(op_bits);
        cmd_wr   = wr && (addr == OFS_CMD);
        op_start = cmd_wr && (op == OP_START);
        op_idle  = cmd_wr && (op == OP_IDLE);
        op_abort = cmd_wr && (op == OP_ABORT);
    end

    always_comb begin
        assert ($countones({op_start, op_idle, op_abort}) <= 1)
            else $error("assert_one_op_R2 failed");
    end
endmodule

// File: rtl/scsi_dma_status.sv
module scsi_dma_status
    import scsi_dma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_clr,
    input  logic              stat_wr,
    input  logic              stat_rd,
    input  logic [2:0]        wr_bits,
    input  logic              clr_on_read,
    input  logic [2:0]        set_evt,
    input  logic              scsi_irq,
    output logic [STAT_W-1:0] stat_view
);
    logic [STAT_W-1:0] stat_d, stat_q;

    always_comb begin
        stat_d = stat_q;
        if (start_clr) begin
            stat_d = '0;
        end
        if (stat_wr && !clr_on_read) begin
            stat_d[3:1] = stat_d[3:1] & ~wr_bits;
        end
        if (stat_rd && clr_on_read) begin
            stat_d[3:1] = 3'b000;
        end
        stat_d[3:1] = stat_d[3:1] | set_evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_d;
    end

    always_comb begin
        stat_view    = stat_q;
        stat_view[4] = stat_q[4] | scsi_irq;
    end

    assert_rd_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && clr_on_read && set_evt == 3'b000) |=> stat_q[3:1] == 3'b000);

    assert_wr_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && clr_on_read && !stat_rd && !start_clr && set_evt == 3'b000)
        |=> $stable(stat_q));

    assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt[2] |=> stat_q[3]);
endmodule

// File: rtl/scsi_dma_ctrl.sv
module scsi_dma_ctrl
    import scsi_dma_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    input  logic              clr_on_read,
    input  logic              scsi_irq,
    input  logic [2:0]        stat_set,
    output logic [DW-1:0]     reg_rdata,
    output logic              dma_en,
    output logic              xfer_cancel
);
    localparam logic [DW-1:0] WADR_RST = {DW{1'b1}};
    localparam logic [DW-1:0] WDSC_RST = {DW{1'b1}} - DW'(2);

    typedef struct packed {
        logic [CMD_W-1:0] cmd;
        logic [DW-1:0]    scnt;
        logic [DW-1:0]    sadr;
        logic [DW-1:0]    sdsc;
        logic [DW-1:0]    wcnt;
        logic [DW-1:0]    wadr;
        logic [DW-1:0]    wdsc;
        logic             en;
        logic             cancel;
    } ctl_regs_t;

    ctl_regs_t r_d, r_q;
    logic cmd_wr, op_start, op_idle, op_abort;
    logic [STAT_W-1:0] stat_view;

    scsi_dma_cmd_dec dec_i (
        .wr       (reg_wr),
        .addr     (reg_addr),
        .op_bits  (reg_wdata[1:0]),
        .cmd_wr   (cmd_wr),
        .op_start (op_start),
        .op_idle  (op_idle),
        .op_abort (op_abort)
    );

    scsi_dma_status stat_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_clr   (op_start),
        .stat_wr     (reg_wr && reg_addr == OFS_STAT),
        .stat_rd     (reg_rd && reg_addr == OFS_STAT),
        .wr_bits     (reg_wdata[3:1]),
        .clr_on_read (clr_on_read),
        .set_evt     (stat_set),
        .scsi_irq    (scsi_irq),
        .stat_view   (stat_view)
    );

    always_comb begin
        r_d        = r_q;
        r_d.cancel = 1'b0;
        if (cmd_wr) r_d.cmd = reg_wdata[CMD_W-1:0];
        if (op_start) begin
            r_d.wcnt = r_q.scnt;
            r_d.wadr = r_q.sadr;
            r_d.wdsc = r_q.sdsc;
            r_d.en   = 1'b1;
        end
        if (op_idle)  r_d.en     = 1'b0;
        if (op_abort) r_d.cancel = 1'b1;
        if (reg_wr) begin
            case (reg_addr)
                OFS_SCNT: r_d.scnt = reg_wdata;
                OFS_SADR: r_d.sadr = reg_wdata;
                OFS_SDSC: r_d.sdsc = reg_wdata;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.wadr <= WADR_RST;
            r_q.wdsc <= WDSC_RST;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        case (reg_addr)
            OFS_CMD:  reg_rdata = {{(DW-CMD_W){1'b0}}, r_q.cmd};
            OFS_SCNT: reg_rdata = r_q.scnt;
            OFS_SADR: reg_rdata = r_q.sadr;
            OFS_WCNT: reg_rdata = r_q.wcnt;
            OFS_WADR: reg_rdata = r_q.wadr;
            OFS_STAT: reg_rdata = {{(DW-STAT_W){1'b0}}, stat_view};
            OFS_SDSC: reg_rdata = r_q.sdsc;
            default:  reg_rdata = r_q.wdsc;
        endcase
    end

    assign dma_en      = r_q.en;
    assign xfer_cancel = r_q.cancel;

    assert_start_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |=> (r_q.wcnt == $past(r_q.scnt)) && (r_q.wadr == $past(r_q.sadr))
                     && dma_en);

    assert_idle_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        op_idle |=> !dma_en);

    assert_cancel_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_cancel |=> !xfer_cancel);

    assert_work_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && (reg_addr == OFS_WCNT || reg_addr == OFS_WADR || reg_addr == OFS_WDSC))
        |=> $stable(r_q.wcnt) && $stable(r_q.wadr) && $stable(r_q.wdsc));
endmodule

// File: tb/scsi_dma_ctrl_tb.sv
`timescale 1ns/1ps
module scsi_dma_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic        clr_on_read = 1'b0, scsi_irq = 1'b0;
    logic [2:0]  stat_set = 3'b000;
    logic [31:0] reg_rdata;
    logic        dma_en, xfer_cancel;

    int n_chk = 0, n_fail = 0;
    logic [31:0] m [8];
    logic        m_en, m_cancel;

    always #2.5 clk = ~clk;

    scsi_dma_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .clr_on_read(clr_on_read),
        .scsi_irq(scsi_irq), .stat_set(stat_set), .reg_rdata(reg_rdata),
        .dma_en(dma_en), .xfer_cancel(xfer_cancel)
    );

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic step(string tag, logic wr, logic rd, logic [2:0] a, logic [31:0] wd,
                        logic mode, logic irq, logic [2:0] set);
        logic [31:0] exp_rd;
        @(negedge clk);
        reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = wd;
        clr_on_read = mode; scsi_irq = irq; stat_set = set;
        #1;
        exp_rd = (a == 3'd5) ? (m[5] | (irq ? 32'h10 : 32'h0)) : m[a];
        chk(tag, "rdata", reg_rdata, exp_rd);
        chk(tag, "dma_en", {31'd0, dma_en}, {31'd0, m_en});
        chk(tag, "cancel", {31'd0, xfer_cancel}, {31'd0, m_cancel});
        @(posedge clk);
        m_cancel = 1'b0;
        if (wr) begin
            if (a == 3'd0) begin
                m[0] = wd & 32'hFF;
                if (wd[1:0] == 2'd3) begin
                    m[3] = m[1]; m[4] = m[2]; m[7] = m[6];
                    m[5] = 32'd0; m_en = 1'b1;
                end else if (wd[1:0] == 2'd0) m_en = 1'b0;
                else if (wd[1:0] == 2'd2) m_cancel = 1'b1;
            end
            if (a == 3'd1 || a == 3'd2 || a == 3'd6) m[a] = wd;
            if (a == 3'd5 && !mode) m[5] = m[5] & ~(wd & 32'hE);
        end
        if (rd && a == 3'd5 && mode) m[5] = m[5] & ~32'hE;
        m[5] = m[5] | ({29'd0, set} << 1);
    endtask

    initial begin
        #500000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) m[i] = 32'd0;
        m[4] = 32'hFFFF_FFFF; m[7] = 32'hFFFF_FFFD;
        m_en = 1'b0; m_cancel = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1: reset values of every register
        for (int i = 0; i < 8; i++) step("R1", 0, 0, 3'(i), 0, 0, 0, 0);
        // R11: start registers store full words
        step("R11", 1, 0, 3'd1, 32'h0001_2345, 0, 0, 0);
        step("R11", 1, 0, 3'd2, 32'hDEAD_BEEF, 0, 0, 0);
        step("R11", 1, 0, 3'd6, 32'hCAFE_F00D, 0, 0, 0);
        step("R11", 0, 0, 3'd1, 0, 0, 0, 0);
        step("R11", 0, 0, 3'd2, 0, 0, 0, 0);
        step("R11", 0, 0, 3'd6, 0, 0, 0, 0);
        // R9: working registers are not writable
        step("R9", 1, 0, 3'd3, 32'h1111_1111, 0, 0, 0);
        step("R9", 1, 0, 3'd4, 32'h2222_2222, 0, 0, 0);
        step("R9", 1, 0, 3'd7, 32'h3333_3333, 0, 0, 0);
        for (int i = 3; i < 8; i += 1) step("R9", 0, 0, 3'(i), 0, 0, 0, 0);
        // R10: set events
        step("R10", 0, 0, 3'd5, 0, 0, 0, 3'b111);
        step("R10", 0, 0, 3'd5, 0, 0, 0, 0);
        // R3: START loads working registers and clears status
        step("R3", 1, 0, 3'd0, 32'h0000_0083, 0, 0, 0);
        step("R3", 1, 0, 3'd1, 32'h0000_0055, 0, 0, 0);
        for (int i = 3; i < 8; i++) step("R3", 0, 0, 3'(i), 0, 0, 0, 0);
        step("R2", 0, 0, 3'd0, 0, 0, 0, 0);
        // R6: write-to-clear
        step("R6", 0, 0, 3'd5, 0, 0, 0, 3'b111);
        step("R6", 1, 0, 3'd5, 32'hFFFF_FFF4, 0, 0, 0);
        step("R6", 0, 0, 3'd5, 0, 0, 0, 0);
        step("R6", 1, 0, 3'd5, 32'h0000_000A, 0, 0, 0);
        step("R6", 0, 0, 3'd5, 0, 0, 0, 0);
        // R10: set beats write clear
        step("R10", 1, 0, 3'd5, 32'hE, 0, 0, 3'b100);
        step("R10", 0, 0, 3'd5, 0, 0, 0, 0);
        // R8: live interrupt merged into read
        step("R8", 0, 0, 3'd5, 0, 0, 1, 0);
        step("R8", 0, 1, 3'd5, 0, 1, 1, 0);
        step("R8", 0, 0, 3'd5, 0, 0, 0, 0);
        // R7: read-to-clear, writes ignored
        step("R7", 0, 0, 3'd5, 0, 1, 0, 3'b011);
        step("R7", 1, 0, 3'd5, 32'hE, 1, 0, 0);
        step("R7", 0, 1, 3'd5, 0, 1, 0, 0);
        step("R7", 0, 0, 3'd5, 0, 1, 0, 0);
        // R10: set beats read clear
        step("R10", 0, 0, 3'd5, 0, 1, 0, 3'b101);
        step("R10", 0, 1, 3'd5, 0, 1, 0, 3'b010);
        step("R10", 0, 0, 3'd5, 0, 1, 0, 0);
        // R10: set beats START clear
        step("R10", 1, 0, 3'd0, 32'h3, 0, 0, 3'b001);
        step("R10", 0, 0, 3'd5, 0, 0, 0, 0);
        // R4: BLAST keeps enable, IDLE drops it
        step("R4", 1, 0, 3'd0, 32'h0000_0041, 0, 0, 0);
        step("R4", 0, 0, 3'd0, 0, 0, 0, 0);
        step("R4", 1, 0, 3'd0, 32'h0000_0010, 0, 0, 0);
        step("R4", 0, 0, 3'd0, 0, 0, 0, 0);
        // R5: ABORT single-cycle cancel
        step("R5", 1, 0, 3'd0, 32'hFFFF_FFF2, 0, 0, 0);
        step("R5", 0, 0, 3'd0, 0, 0, 0, 0);
        step("R5", 0, 0, 3'd0, 0, 0, 0, 0);
        step("R5", 1, 0, 3'd0, 32'h3, 0, 0, 0);
        step("R5", 1, 0, 3'd0, 32'h2, 0, 0, 0);
        step("R5", 0, 0, 3'd0, 0, 0, 0, 0);
        step("R5", 0, 0, 3'd0, 0, 0, 0, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule